// File: doc/BRIEF.md
# Slot Power Enable Sequencer

This block controls power for every slot of a modular backplane chassis. Each slot has a module-seated input. Once that input has settled, the slot's low-voltage management rail (3.3 V) is switched on with no further condition. The slot's high-voltage payload rail (12 V) stays off until a separate hub controller asserts a per-slot grant. The hub controller gives that grant only after it has confirmed that the module is compatible. Each slot has its own pair of enables, and no enable is shared between slots.

When a module is pulled, the payload rail is shut before the management rail. Any grant that was already waiting for that slot is discarded, so a fresh grant is needed after the next insertion. Withdrawing the grant while the payload rail is live drops the slot back to management-only power.

The block also chooses which of two supply feeds powers the chassis. The primary feed is used by default. The secondary feed takes over as soon as the primary loses its power-good signal. Selection returns to the primary only after its power-good has stayed high for a hold-off interval.

Top module: `slot_power_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every management and payload enable is 0, every status field reads EMPTY (2'b00), and the primary feed is selected (feed_pri_o=1, feed_sec_o=0).
- R2: Each slot is handled independently. One clock edge after a slot's filtered presence becomes 1, that slot's management enable turns on without any grant. A payload enable is never 1 while the management enable of the same slot is 0.
- R3: The presence input of each slot (1 = module seated) takes effect only after it has held a new level on DEB_CYCLES consecutive clock edges. A pulse shorter than that has no effect on the enables.
- R4: A payload enable rises only when all of these hold: the slot is in management-only state, its grant input (1 = granted) is high, and the grant has been seen low at least once since the module was detected. A grant held high across an insertion therefore has no effect until it is released and given again.
- R5: On a filtered removal from the payload-on state, the payload enable goes low first. The management enable goes low exactly one edge later.
- R6: Dropping the grant while the payload rail is on turns the payload enable off on the next edge and leaves the management enable on.
- R7: Exactly one of feed_pri_o and feed_sec_o is high on every cycle.
- R8: A clock edge that samples pri_good_i low selects the secondary feed.
- R9: Once the secondary feed is selected, the primary is selected again on the HOLD_CYCLES-th consecutive edge that samples pri_good_i high. Any low sample restarts the count.
- R10: Each slot's 2-bit status field reads 2'b00 when the management rail is off, 2'b10 when the payload rail is on, and 2'b01 when only the management rail is on. Slot i uses bits [2i+1:2i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| present_i | input | NUM_SLOTS | Raw module-seated input, one bit per slot |
| grant_i | input | NUM_SLOTS | Payload grant from the hub controller, one bit per slot |
| pri_good_i | input | 1 | Primary feed power-good |
| mgmt_en_o | output | NUM_SLOTS | Management rail enable per slot |
| payload_en_o | output | NUM_SLOTS | Payload rail enable per slot |
| status_o | output | 2*NUM_SLOTS | Per-slot state field |
| feed_pri_o | output | 1 | Primary feed selected |
| feed_sec_o | output | 1 | Secondary feed selected |

## Verification
The assertions check the following on every cycle:
- the feed selection stays one-hot;
- no slot ever has payload power without management power;
- each status code agrees with that slot's enables;
- a payload rise always follows a sampled grant;
- the management rail never falls while the payload rail was on the cycle before;
- a low power-good moves the chassis to the secondary feed.

Some behaviour only the bench's scenarios can show, because it depends on history:
- a short presence glitch is filtered;
- a grant held high across an insertion stays ignored until it is toggled;
- the exact one-edge gap between the two rails switching off on removal;
- a power-good dip in the middle of the hold-off restarts the return count.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_MGMT  = 2'd1,
    SLOT_LIVE  = 2'd2,
    SLOT_DRAIN = 2'd3
  } slot_state_e;
endpackage

// File: rtl/sps_debounce.sv
module sps_debounce #(
  parameter int DEB_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;

  // Count edges on which the raw level disagrees with the filtered level.
  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (raw_i == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
      lvl_d = raw_i;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign clean_o = lvl_q;
endmodule

// File: rtl/sps_slot_fsm.sv
module sps_slot_fsm
  import sps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seated_i,
  input  logic       grant_i,
  output logic       mgmt_en_o,
  output logic       payload_en_o,
  output logic [1:0] status_o
);
  slot_state_e st_q, st_d;
  logic        armed_q, armed_d;

  // A grant only counts once it has been seen low since the module arrived.
  always_comb begin
    if (!seated_i)     armed_d = 1'b0;
    else if (!grant_i) armed_d = 1'b1;
    else               armed_d = armed_q;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SLOT_EMPTY: if (seated_i) st_d = SLOT_MGMT;
      SLOT_MGMT: begin
        if (!seated_i)                st_d = SLOT_EMPTY;
        else if (grant_i && armed_q)  st_d = SLOT_LIVE;
      end
      SLOT_LIVE: begin
        if (!seated_i)     st_d = SLOT_DRAIN;
        else if (!grant_i) st_d = SLOT_MGMT;
      end
      SLOT_DRAIN: st_d = SLOT_EMPTY;
      default:    st_d = SLOT_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SLOT_EMPTY;
      armed_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
    end
  end

  assign mgmt_en_o    = (st_q != SLOT_EMPTY);
  assign payload_en_o = (st_q == SLOT_LIVE);
  assign status_o     = (st_q == SLOT_DRAIN) ? 2'd1 : st_q;
endmodule

// File: rtl/sps_feed_sel.sv
module sps_feed_sel #(
  parameter int HOLD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pri_good_i,
  output logic use_sec_o
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0] hold_q, hold_d;
  logic          sec_q, sec_d;

  always_comb begin
    sec_d  = sec_q;
    hold_d = hold_q;
    if (!pri_good_i) begin
      sec_d  = 1'b1;
      hold_d = '0;
    end else if (sec_q) begin
      if (hold_q == HW'(HOLD_CYCLES - 1)) begin
        sec_d  = 1'b0;
        hold_d = '0;
      end else begin
        hold_d = hold_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      sec_q  <= sec_d;
      hold_q <= hold_d;
    end
  end

  assign use_sec_o = sec_q;
endmodule

// File: rtl/slot_power_seq.sv
module slot_power_seq #(
  parameter int NUM_SLOTS   = 4,
  parameter int DEB_CYCLES  = 4,
  parameter int HOLD_CYCLES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SLOTS-1:0]   present_i,
  input  logic [NUM_SLOTS-1:0]   grant_i,
  input  logic                   pri_good_i,
  output logic [NUM_SLOTS-1:0]   mgmt_en_o,
  output logic [NUM_SLOTS-1:0]   payload_en_o,
  output logic [2*NUM_SLOTS-1:0] status_o,
  output logic                   feed_pri_o,
  output logic                   feed_sec_o
);
  logic [NUM_SLOTS-1:0] seated;
  logic                 use_sec;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    sps_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (present_i[s]),
      .clean_o (seated[s])
    );
    sps_slot_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .seated_i     (seated[s]),
      .grant_i      (grant_i[s]),
      .mgmt_en_o    (mgmt_en_o[s]),
      .payload_en_o (payload_en_o[s]),
      .status_o     (status_o[2*s +: 2])
    );
  end

  sps_feed_sel #(.HOLD_CYCLES(HOLD_CYCLES)) u_feed (
    .clk        (clk),
    .rst_n      (rst_n),
    .pri_good_i (pri_good_i),
    .use_sec_o  (use_sec)
  );

  assign feed_sec_o = use_sec;
  assign feed_pri_o = ~use_sec;
endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
  parameter int NUM_SLOTS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_SLOTS-1:0]   grant_i,
  input logic                   pri_good_i,
  input logic [NUM_SLOTS-1:0]   mgmt_en_o,
  input logic [NUM_SLOTS-1:0]   payload_en_o,
  input logic [2*NUM_SLOTS-1:0] status_o,
  input logic                   feed_pri_o,
  input logic                   feed_sec_o
);
  a_r7_feed_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({feed_pri_o, feed_sec_o}) == 1);

  a_r8_failover: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_good_i |=> feed_sec_o);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
    a_r2_payload_needs_mgmt: assert property (@(posedge clk) disable iff (!rst_n)
      payload_en_o[s] |-> mgmt_en_o[s]);

    a_r4_rise_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(payload_en_o[s]) |-> $past(grant_i[s]));

    a_r5_payload_first: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mgmt_en_o[s]) |-> !$past(payload_en_o[s]));

    a_r10_status_code: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_o[2*s +: 2] == 2'd2) == payload_en_o[s]) &&
      ((status_o[2*s +: 2] == 2'd0) == !mgmt_en_o[s]));
  end
endmodule

bind slot_power_seq sps_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .grant_i      (grant_i),
  .pri_good_i   (pri_good_i),
  .mgmt_en_o    (mgmt_en_o),
  .payload_en_o (payload_en_o),
  .status_o     (status_o),
  .feed_pri_o   (feed_pri_o),
  .feed_sec_o   (feed_sec_o)
);

// File: tb/sim_slot_power_seq.sv
`timescale 1ns/1ps
module sim_slot_power_seq;
  localparam int N    = 4;
  localparam int DEB  = 4;
  localparam int HOLD = 8;

  logic           clk;
  logic           rst_n;
  logic [N-1:0]   present;
  logic [N-1:0]   grant;
  logic           pg;
  logic [N-1:0]   mgmt_en;
  logic [N-1:0]   pay_en;
  logic [2*N-1:0] status;
  logic           f_pri;
  logic           f_sec;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  slot_power_seq #(.NUM_SLOTS(N), .DEB_CYCLES(DEB), .HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .present_i(present), .grant_i(grant),
    .pri_good_i(pg), .mgmt_en_o(mgmt_en), .payload_en_o(pay_en),
    .status_o(status), .feed_pri_o(f_pri), .feed_sec_o(f_sec));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural reference: per slot a run counter, a filtered level,
  // a "grant seen low" flag and a phase number (0 off, 1 mgmt, 2 live, 3 draining).
  int m_run[N];
  bit m_lvl[N];
  bit m_seen[N];
  int m_ph[N];
  bit m_sec;
  int m_hold;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N; s++) begin
        m_run[s] = 0; m_lvl[s] = 0; m_seen[s] = 0; m_ph[s] = 0;
      end
      m_sec = 0; m_hold = 0;
    end else begin
      for (int s = 0; s < N; s++) begin
        int nph;
        bit nl;
        bit nseen;
        int nrun;
        nl = m_lvl[s]; nrun = m_run[s] + 1;
        if (present[s] == m_lvl[s]) nrun = 0;
        else if (nrun == DEB) begin nl = present[s]; nrun = 0; end
        nseen = !m_lvl[s] ? 1'b0 : (!grant[s] ? 1'b1 : m_seen[s]);
        nph = m_ph[s];
        if (m_ph[s] == 0 && m_lvl[s]) nph = 1;
        else if (m_ph[s] == 1 && !m_lvl[s]) nph = 0;
        else if (m_ph[s] == 1 && grant[s] && m_seen[s]) nph = 2;
        else if (m_ph[s] == 2 && !m_lvl[s]) nph = 3;
        else if (m_ph[s] == 2 && !grant[s]) nph = 1;
        else if (m_ph[s] == 3) nph = 0;
        m_run[s] = nrun; m_lvl[s] = nl; m_seen[s] = nseen; m_ph[s] = nph;
      end
      if (!pg) begin m_sec = 1; m_hold = 0; end
      else if (m_sec) begin
        m_hold++;
        if (m_hold == HOLD) begin m_sec = 0; m_hold = 0; end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare against the reference on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int s = 0; s < N; s++) begin
        int es;
        es = (m_ph[s] == 3) ? 1 : m_ph[s];
        check(mgmt_en[s] == (m_ph[s] != 0), "R2 mgmt enable", mgmt_en[s], m_ph[s] != 0);
        check(pay_en[s] == (m_ph[s] == 2), "R4 payload enable", pay_en[s], m_ph[s] == 2);
        check(int'(status[2*s +: 2]) == es, "R10 status", status[2*s +: 2], es);
      end
      check(f_sec == m_sec, "R8 feed select", f_sec, m_sec);
      check(f_pri == !m_sec, "R7 feed onehot", f_pri, !m_sec);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; present = '0; grant = '0; pg = 1'b1;
    tick(1);
    check(mgmt_en == '0 && pay_en == '0 && status == '0, "R1 reset enables", mgmt_en, 0);
    check(f_pri && !f_sec, "R1 reset feed", f_sec, 0);
    tick(2);
    rst_n = 1;
    tick(1);
    check(mgmt_en == '0 && status == '0 && f_pri, "R1 after release", mgmt_en, 0);

    // R3: short glitch on slot 0 is ignored
    present[0] = 1; tick(DEB - 1); present[0] = 0;
    tick(DEB + 3);
    check(mgmt_en[0] == 0, "R3 glitch filtered", mgmt_en[0], 0);

    // R2: insertion enables management only, slot 3 untouched
    present[0] = 1; tick(DEB + 2);
    check(mgmt_en[0] == 1 && pay_en[0] == 0, "R2 mgmt after insert", mgmt_en[0], 1);
    check(mgmt_en[3] == 0, "R2 other slot idle", mgmt_en[3], 0);

    // R4: grant turns payload on
    grant[0] = 1; tick(1);
    check(pay_en[0] == 1 && status[1:0] == 2'd2, "R4 payload granted", pay_en[0], 1);

    // R4: grant held high across insertion must be toggled
    grant[1] = 1; present[1] = 1; tick(DEB + 6);
    check(mgmt_en[1] == 1 && pay_en[1] == 0, "R4 stale grant ignored", pay_en[1], 0);
    grant[1] = 0; tick(1); grant[1] = 1; tick(1);
    check(pay_en[1] == 1, "R4 fresh grant", pay_en[1], 1);

    // R6: revoke while live
    grant[0] = 0; tick(1);
    check(pay_en[0] == 0 && mgmt_en[0] == 1 && status[1:0] == 2'd1, "R6 revoke", pay_en[0], 0);
    grant[0] = 1; tick(1);
    check(pay_en[0] == 1, "R6 regrant", pay_en[0], 1);

    // R5: removal ordering
    present[0] = 0;
    for (int k = 0; k < 20 && pay_en[0]; k++) tick(1);
    check(pay_en[0] == 0 && mgmt_en[0] == 1, "R5 payload off first", mgmt_en[0], 1);
    tick(1);
    check(mgmt_en[0] == 0, "R5 mgmt off next", mgmt_en[0], 0);

    // R4: pending grant cleared on removal, reinsertion needs a new grant
    present[0] = 1; tick(DEB + 6);
    check(mgmt_en[0] == 1 && pay_en[0] == 0, "R4 grant cleared on removal", pay_en[0], 0);

    // R8: failover on power-good low
    pg = 0; tick(1);
    check(f_sec == 1 && f_pri == 0, "R8 failover", f_sec, 1);
    // R9: dip restarts hold-off
    pg = 1; tick(HOLD - 3); pg = 0; tick(1); pg = 1;
    tick(HOLD - 1);
    check(f_sec == 1, "R9 hold-off pending", f_sec, 1);
    tick(1);
    check(f_pri == 1 && f_sec == 0, "R9 primary restored", f_pri, 1);

    // Extra mixed pattern: slot 2 and 3 together, then rapid removal
    present[3:2] = 2'b11; grant[3:2] = 2'b00; tick(DEB + 2);
    grant[3:2] = 2'b11; tick(2);
    check(pay_en[3:2] == 2'b11, "R2 independent slots", pay_en[3:2], 3);
    present[2] = 0; grant[3] = 0; tick(DEB + 4);
    check(mgmt_en[2] == 0 && mgmt_en[3] == 1 && pay_en[3] == 0, "R6 mixed", mgmt_en, 0);

    tick(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule